// File: doc/BRIEF.md
# Parallel Host Register Port

This block is a slave on an asynchronous parallel host bus with chip select, data/command select, write strobe, read strobe and a 16-bit data bus. A write with the data/command select low loads an 8-bit register index. Later data writes and reads go to the register at that index through a simple register-file interface. Accesses to the memory port index are sent instead to a pixel-memory interface that has its own address pointer. The register index moves forward by one after each ordinary data access, so a host can stream a run of consecutive registers after a single command.

Two indices are special. At the memory port (48h or 49h) and at the table data register (52h), the index stays where it is. At the memory port the memory pointer advances instead. At the table register any pointer advance is left to the register file. Three ordinary registers (4Ah, 4Bh and 4Ch) also load the memory pointer one byte each, low byte first, and bit 0 of the pointer is always cleared on load.

All strobes and data pass through two synchronising flops into the system clock. One controller state machine turns a rising write strobe or a falling read strobe into a single access cycle. Its states are S_IDLE, S_WRITE, S_READ and S_RD_WAIT:
- S_IDLE goes to S_WRITE on a selected write-strobe rise, or to S_READ on a selected read-strobe fall.
- S_WRITE always returns to S_IDLE.
- S_READ always goes to S_RD_WAIT.
- S_RD_WAIT returns to S_IDLE once the read strobe or the chip select is high again.

A width input chooses 16-bit memory transfers. A swap input reverses the order of the host data lanes.

Top module: `hrp_host_port`

## Requirements
- R1: A write-strobe rising edge with cs_n low and dc_n low loads the register index from internal data bits 7:0. A rising edge with dc_n high writes internal bits 7:0 to the register at the index through reg_we, reg_addr and reg_wdata.
- R2: After each data write or read of an ordinary register, the index increments by one, wrapping at 8 bits.
- R3: A data access at index 48h or 49h goes to the memory interface at the pointer and not to the register file, and the index does not change.
- R4: A data write at index 4Ah, 4Bh or 4Ch stores the byte in the register file and also loads pointer bits 7:0 (with bit 0 forced to 0), bits 15:8, or the bits above 15, respectively. The index then increments as for any ordinary register.
- R5: A data write or read at index 52h uses the register file, and the index does not change.
- R6: Register accesses use internal bits 7:0 only. With wide_bus=1, a memory access carries all 16 bits and the pointer advances by 2. With wide_bus=0, it carries bits 7:0 (upper bits written as 0 and read as 0) and the pointer advances by 1.
- R7: With lane_swap=1, host line 15-i maps to internal bit i, for both writes and read data.
- R8: A read-strobe falling edge with cs_n low performs a read. A register read returns the byte on internal bits 7:0 with bits 15:8 zero. A memory read returns the word at the pointer and then advances the pointer. data_oe is high while cs_n and rd_n are both low.
- R9: While cs_n is high, strobes have no effect and data_oe is low.
- R10: After reset, the index and the pointer are 0, no access strobe is active, and data_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip select, active low |
| dc_n | input | 1 | Host data/command select, low for index load |
| wr_n | input | 1 | Host write strobe, active low |
| rd_n | input | 1 | Host read strobe, active low |
| data_in | input | 16 | Host data lines, host to block |
| data_out | output | 16 | Host data lines, block to host |
| data_oe | output | 1 | Output enable for data_out |
| wide_bus | input | 1 | 1 selects 16-bit memory port transfers |
| lane_swap | input | 1 | 1 reverses host data lane order |
| reg_addr | output | 8 | Register file index |
| reg_wdata | output | 8 | Register file write data |
| reg_we | output | 1 | Register file write, one cycle |
| reg_re | output | 1 | Register file read, one cycle |
| reg_rdata | input | 8 | Register file read data, valid in the reg_re cycle |
| mem_addr | output | 19 | Pixel memory address |
| mem_wdata | output | 16 | Pixel memory write data |
| mem_we | output | 1 | Pixel memory write, one cycle |
| mem_re | output | 1 | Pixel memory read, one cycle |
| mem_rdata | input | 16 | Pixel memory read data, valid in the mem_re cycle |

## Verification
The assertions on pointer steps assume that wide_bus and lane_swap change only between host cycles. They also assume that each strobe pulse is long enough, and separated from the next by enough time, for the two-flop synchronisers to see it. The bench drives every strobe low and high for several clock periods and holds data and dc_n stable around each strobe. It changes the configuration inputs only while the chip is deselected. Random register streams stay below the special indices so that the expected contents follow from plain increments.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_WRITE,
        S_READ,
        S_RD_WAIT
    } hrp_state_e;
endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
    parameter int WIDTH   = 4,
    parameter int STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hrp_lane.sv
module hrp_lane #(
    parameter int W = 16
) (
    input  logic         swap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign q[i] = swap ? d[W-1-i] : d[i];
    end
endmodule

// File: rtl/hrp_ctrl.sv
module hrp_ctrl
    import hrp_pkg::*;
#(
    parameter int         AW      = 19,
    parameter logic [7:0] MEM_LO  = 8'h48,
    parameter logic [7:0] MEM_HI  = 8'h49,
    parameter logic [7:0] TBL_IDX = 8'h52,
    parameter logic [7:0] PTR_B0  = 8'h4A,
    parameter logic [7:0] PTR_B1  = 8'h4B,
    parameter logic [7:0] PTR_B2  = 8'h4C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          dc_s,
    input  logic          wr_s,
    input  logic          rd_s,
    input  logic [15:0]   wdat,
    input  logic          wide,
    input  logic [7:0]    reg_rdata,
    input  logic [15:0]   mem_rdata,
    output logic [7:0]    reg_addr,
    output logic [7:0]    reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    output logic [15:0]   rdat
);
    localparam int HI_W = AW - 16;

    hrp_state_e state, nxt;
    logic          wr_p, rd_p;
    logic          wr_rise, rd_fall;
    logic          cmd_q;
    logic [15:0]   dat_q;
    logic [7:0]    idx;
    logic [AW-1:0] ptr;
    logic          is_mem;
    logic [AW-1:0] step;

    assign wr_rise = wr_s & ~wr_p & ~cs_s;
    assign rd_fall = ~rd_s & rd_p & ~cs_s;
    assign is_mem  = (idx == MEM_LO) || (idx == MEM_HI);
    assign step    = wide ? AW'(2) : AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (wr_rise)      nxt = S_WRITE;
                else if (rd_fall) nxt = S_READ;
            end
            S_WRITE:   nxt = S_IDLE;
            S_READ:    nxt = S_RD_WAIT;
            S_RD_WAIT: if (rd_s || cs_s) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_p  <= 1'b1;
            rd_p  <= 1'b1;
            cmd_q <= 1'b0;
            dat_q <= '0;
            idx   <= '0;
            ptr   <= '0;
            rdat  <= '0;
        end else begin
            wr_p <= wr_s;
            rd_p <= rd_s;
            if (state == S_IDLE && wr_rise) begin
                cmd_q <= ~dc_s;
                dat_q <= wdat;
            end
            if (state == S_WRITE) begin
                if (cmd_q) begin
                    idx <= dat_q[7:0];
                end else if (is_mem) begin
                    ptr <= ptr + step;
                end else begin
                    if (idx != TBL_IDX) idx <= idx + 8'd1;
                    if (idx == PTR_B0) ptr[7:0]     <= {dat_q[7:1], 1'b0};
                    if (idx == PTR_B1) ptr[15:8]    <= dat_q[7:0];
                    if (idx == PTR_B2) ptr[AW-1:16] <= dat_q[HI_W-1:0];
                end
            end
            if (state == S_READ) begin
                if (is_mem) begin
                    ptr  <= ptr + step;
                    rdat <= wide ? mem_rdata : {8'h00, mem_rdata[7:0]};
                end else begin
                    rdat <= {8'h00, reg_rdata};
                    if (idx != TBL_IDX) idx <= idx + 8'd1;
                end
            end
        end
    end

    always_comb begin
        reg_addr  = idx;
        reg_wdata = dat_q[7:0];
        reg_we    = (state == S_WRITE) && !cmd_q && !is_mem;
        reg_re    = (state == S_READ) && !is_mem;
        mem_we    = (state == S_WRITE) && !cmd_q && is_mem;
        mem_re    = (state == S_READ) && is_mem;
        mem_wdata = wide ? dat_q : {8'h00, dat_q[7:0]};
        mem_addr  = wide ? {ptr[AW-1:1], 1'b0} : ptr;
    end
endmodule

// File: rtl/hrp_host_port.sv
module hrp_host_port #(
    parameter int AW     = 19,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          dc_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic [15:0]   data_in,
    output logic [15:0]   data_out,
    output logic          data_oe,
    input  logic          wide_bus,
    input  logic          lane_swap,
    output logic [7:0]    reg_addr,
    output logic [7:0]    reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    input  logic [7:0]    reg_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    input  logic [15:0]   mem_rdata
);
    logic [3:0]  strb_s;
    logic [15:0] din_s, din_int, rdat;

    hrp_sync #(.WIDTH(4), .STAGES(STAGES), .RST_VAL(4'hF)) u_sync_strb (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n, dc_n, wr_n, rd_n}), .q(strb_s)
    );

    hrp_sync #(.WIDTH(16), .STAGES(STAGES), .RST_VAL(16'h0000)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .d(data_in), .q(din_s)
    );

    hrp_lane #(.W(16)) u_lane_in  (.swap(lane_swap), .d(din_s), .q(din_int));
    hrp_lane #(.W(16)) u_lane_out (.swap(lane_swap), .d(rdat),  .q(data_out));

    hrp_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cs_s(strb_s[3]), .dc_s(strb_s[2]), .wr_s(strb_s[1]), .rd_s(strb_s[0]),
        .wdat(din_int), .wide(wide_bus),
        .reg_rdata(reg_rdata), .mem_rdata(mem_rdata),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .rdat(rdat)
    );

    assign data_oe = ~cs_n & ~rd_n;
endmodule

// File: rtl/hrp_checker.sv
module hrp_checker #(
    parameter int         AW      = 19,
    parameter logic [7:0] MEM_LO  = 8'h48,
    parameter logic [7:0] TBL_IDX = 8'h52
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          wide_bus,
    input logic          data_oe,
    input logic [7:0]    reg_addr,
    input logic          reg_we,
    input logic          reg_re,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          mem_re
);
    // R1: at most one access strobe per cycle
    p_single_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, reg_re, mem_we, mem_re}));

    p_index_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_we || reg_re) && reg_addr != TBL_IDX) |=> reg_addr == 8'($past(reg_addr) + 8'd1));

    p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |=> $stable(reg_addr));

    p_tbl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_we || reg_re) && reg_addr == TBL_IDX) |=> $stable(reg_addr));

    p_wide_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && wide_bus) |=> mem_addr == AW'($past(mem_addr) + AW'(2)));

    p_narrow_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && !wide_bus) |=> mem_addr == AW'($past(mem_addr) + AW'(1)));

    p_deselect_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !data_oe);
endmodule

bind hrp_host_port hrp_checker #(.AW(AW)) u_chk (.*);

// File: tb/tb_hrp_host_port.sv
module tb_hrp_host_port;
    localparam int AW = 19;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, dc_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [15:0] data_in = '0;
    logic [15:0] data_out;
    logic data_oe;
    logic wide_bus = 1'b1, lane_swap = 1'b0;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic reg_we, reg_re, mem_we, mem_re;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    logic [7:0]  rf [256];
    logic [15:0] mm [256];
    logic [7:0]  expf [256];
    int tbl_cnt = 0;
    logic [7:0] tbl_last = '0;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    hrp_host_port #(.AW(AW)) dut (.*);

    assign reg_rdata = rf[reg_addr];
    assign mem_rdata = mm[mem_addr[7:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                rf[i] <= 8'(i) ^ 8'h5A;
                mm[i] <= 16'h0000;
            end
        end else begin
            if (reg_we) rf[reg_addr] <= reg_wdata;
            if (reg_we && reg_addr == 8'h52) begin
                tbl_cnt  <= tbl_cnt + 1;
                tbl_last <= reg_wdata;
            end
            if (mem_we) mm[mem_addr[7:0]] <= mem_wdata;
        end
    end

    function automatic logic [15:0] rev16(input logic [15:0] v);
        for (int i = 0; i < 16; i++) rev16[i] = v[15-i];
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic dc, input logic [15:0] v);
        @(negedge clk); cs_n = 1'b0; dc_n = dc; data_in = v;
        @(negedge clk); wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic host_cmd(input logic [7:0] idx);
        host_write(1'b0, {8'h00, idx});
    endtask

    task automatic host_read(output logic [15:0] v, output logic oe);
        @(negedge clk); cs_n = 1'b0; dc_n = 1'b1;
        @(negedge clk); rd_n = 1'b0;
        repeat (6) @(negedge clk);
        v = data_out; oe = data_oe;
        rd_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic load_ptr(input logic [7:0] b0);
        host_cmd(8'h4A);
        host_write(1'b1, {8'h00, b0});
        host_write(1'b1, 16'h0000);
        host_write(1'b1, 16'h0000);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %h expected %h", 16'h1, 16'h0);
        finish_up();
    end

    initial begin
        logic [15:0] rv;
        logic oe;
        logic [7:0] s53, s41, s42, b;
        int base, len;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: reset state
        check("R10 oe", {15'd0, data_oe}, 16'h0);
        check("R10 strobes", {12'd0, reg_we, reg_re, mem_we, mem_re}, 16'h0);
        host_write(1'b1, 16'h0066);
        check("R10 index zero", {8'h00, rf[0]}, 16'h0066);
        host_cmd(8'h48);
        host_write(1'b1, 16'hCAFE);
        check("R10 pointer zero", mm[0], 16'hCAFE);

        // R1
        host_cmd(8'h10);
        host_write(1'b1, 16'h00A5);
        check("R1 write at index", {8'h00, rf[8'h10]}, 16'h00A5);

        // R2
        host_cmd(8'h20);
        host_write(1'b1, 16'h0011);
        host_write(1'b1, 16'h0022);
        host_write(1'b1, 16'h0033);
        check("R2 stream 0", {8'h00, rf[8'h20]}, 16'h0011);
        check("R2 stream 1", {8'h00, rf[8'h21]}, 16'h0022);
        check("R2 stream 2", {8'h00, rf[8'h22]}, 16'h0033);

        // R6: register writes ignore upper lines in wide mode
        host_cmd(8'h30);
        host_write(1'b1, 16'hFF5A);
        check("R6 reg low lanes", {8'h00, rf[8'h30]}, 16'h005A);

        // R4 and R3
        load_ptr(8'h05);
        check("R4 ptr reg stored", {8'h00, rf[8'h4A]}, 16'h0005);
        host_cmd(8'h48);
        host_write(1'b1, 16'h1234);
        host_write(1'b1, 16'h5678);
        host_write(1'b1, 16'h9ABC);
        check("R4 bit0 cleared", mm[4], 16'h1234);
        check("R3 mem seq 1", mm[6], 16'h5678);
        check("R3 mem seq 2", mm[8], 16'h9ABC);
        check("R3 reg 48 untouched", {8'h00, rf[8'h48]}, {8'h00, 8'h48 ^ 8'h5A});
        check("R3 reg 49 untouched", {8'h00, rf[8'h49]}, {8'h00, 8'h49 ^ 8'h5A});

        // R8: memory reads and register reads
        load_ptr(8'h04);
        host_cmd(8'h49);
        host_read(rv, oe);
        check("R8 mem read 0", rv, 16'h1234);
        check("R8 oe during read", {15'd0, oe}, 16'h1);
        host_read(rv, oe);
        check("R8 mem read 1", rv, 16'h5678);
        host_cmd(8'h20);
        host_read(rv, oe);
        check("R8 reg read 0", rv, 16'h0011);
        host_read(rv, oe);
        check("R8 reg read 1 R2", rv, 16'h0022);

        // R6 narrow memory mode
        @(negedge clk); wide_bus = 1'b0;
        load_ptr(8'h10);
        host_cmd(8'h48);
        host_write(1'b1, 16'hBEEF);
        host_write(1'b1, 16'h00C3);
        check("R6 narrow byte 0", mm[8'h10], 16'h00EF);
        check("R6 narrow byte 1", mm[8'h11], 16'h00C3);
        @(negedge clk); wide_bus = 1'b1;
        load_ptr(8'h21);
        host_cmd(8'h48);
        host_write(1'b1, 16'h7E57);
        check("R4 odd load", mm[8'h20], 16'h7E57);

        // R5
        s53 = rf[8'h53];
        host_cmd(8'h52);
        host_write(1'b1, 16'h0001);
        host_write(1'b1, 16'h0002);
        host_write(1'b1, 16'h0003);
        check("R5 table writes", 16'(tbl_cnt), 16'd3);
        check("R5 table last", {8'h00, tbl_last}, 16'h0003);
        check("R5 next reg untouched", {8'h00, rf[8'h53]}, {8'h00, s53});

        // R7
        @(negedge clk); lane_swap = 1'b1;
        host_write(1'b0, rev16(16'h0040));
        host_write(1'b1, rev16(16'h0077));
        check("R7 swapped write", {8'h00, rf[8'h40]}, 16'h0077);
        host_write(1'b0, rev16(16'h0040));
        host_read(rv, oe);
        check("R7 swapped read", rv, rev16(16'h0077));
        @(negedge clk); lane_swap = 1'b0;

        // R9: index is 41h now; a deselected strobe does nothing
        s41 = rf[8'h41]; s42 = rf[8'h42];
        @(negedge clk); dc_n = 1'b1; data_in = 16'h00EE;
        @(negedge clk); wr_n = 1'b0;
        repeat (3) @(negedge clk); wr_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 ignored write", {8'h00, rf[8'h41]}, {8'h00, s41});
        @(negedge clk); rd_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 oe low deselected", {15'd0, data_oe}, 16'h0);
        rd_n = 1'b1;
        repeat (5) @(negedge clk);
        host_write(1'b1, 16'h0099);
        check("R9 index unmoved", {8'h00, rf[8'h41]}, 16'h0099);
        check("R9 next untouched", {8'h00, rf[8'h42]}, {8'h00, s42});

        // random register streams, R1 and R2
        for (int i = 0; i < 256; i++) expf[i] = rf[i];
        for (int t = 0; t < 20; t++) begin
            base = $urandom_range(0, 60);
            len  = $urandom_range(1, 4);
            @(negedge clk); wide_bus = 1'($urandom_range(0, 1));
            host_cmd(8'(base));
            for (int k = 0; k < len; k++) begin
                b = 8'($urandom);
                expf[base + k] = b;
                host_write(1'b1, {8'($urandom), b});
            end
        end
        for (int i = 0; i < 64; i++) check("R2 random stream", {8'h00, rf[i]}, {8'h00, expf[i]});
        host_cmd(8'h05);
        host_read(rv, oe);
        check("R8 random readback", rv, {8'h00, expf[5]});

        finish_up();
    end
endmodule